// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point numbers and returns their correctly rounded sum. Subtraction is an addition whose operands carry opposite signs, so no separate operation input exists. Operands are accepted with a one-cycle strobe and captured into registers. The result is then formed by a combinational datapath that runs in order: unpack, exponent compare, swap, alignment, effective add or subtract, sign recovery, leading-one normalization, rounding and packing.

Encoding: bit 31 is the sign, bits 30..23 are the exponent with bias 127, and bits 22..0 are the fraction. An exponent field of zero marks a subnormal value: its hidden bit is 0 and its effective exponent is 1. Any other field value gives a hidden bit of 1. An exponent field of 255 with a zero fraction is infinity. With a nonzero fraction it is a NaN. The only rounding mode is round-to-nearest with ties to even.

Control is a two-state machine. `ST_IDLE` means no result is pending. `ST_EMIT` means `sum_out` holds the sum of the last captured pair and `out_valid` is high. Each state goes to `ST_EMIT` on a cycle with `in_valid` high and to `ST_IDLE` on a cycle with `in_valid` low. A synchronous reset forces `ST_IDLE`.

Top module: `fpadd_top`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high and is low otherwise, including during and right after reset. Strobes may come back to back.
- R2: For finite operands of equal sign, `sum_out` is the exact sum rounded to nearest-even.
- R3: For finite operands of opposite sign, `sum_out` is the rounded difference. Its sign is the sign of the operand with the larger magnitude, including when the first operand is the smaller one.
- R4: An exact cancellation of finite operands yields +0 (0x00000000). The sum of two negative zeros yields -0 (0x80000000).
- R5: Subnormal operands use hidden bit 0 and effective exponent 1. Results below the normal range are returned as subnormals with exponent field 0.
- R6: A discarded part of exactly one half LSB rounds to the even neighbour. More than half rounds up.
- R7: When the exponents differ by 26 or more, the smaller operand affects only the sticky bit. The larger operand is returned unless the rounding rule says otherwise.
- R8: A finite sum whose magnitude exceeds the largest finite value, after normalization or rounding, yields signed infinity (0x7F800000 or 0xFF800000).
- R9: A NaN on either input, or infinities of opposite sign, yields the quiet NaN 0x7FC00000.
- R10: An infinity added to a finite value, or to an infinity of the same sign, returns that infinity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: capture `opnd_a` and `opnd_b` this cycle |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| out_valid | output | 1 | High when `sum_out` holds the sum of the pair strobed one cycle earlier |
| sum_out | output | 32 | Rounded sum |

## Verification
Each sum is due one clock after its strobe. The operands are captured at the rising edge that sees `in_valid`, and the sum appears combinationally from those registers. The bench therefore drives a pair at a falling edge and compares it at the next falling edge, just before driving the following pair, so that back-to-back strobes are covered. One cycle after a strobe is withdrawn, the bench checks that `out_valid` has dropped. Expected sums come from an exact wide-integer model in the bench: it aligns both significands to the smaller exponent, adds them, then rounds to nearest-even.

// File: rtl/fpadd_pkg.sv
`timescale 1ns/1ps
package fpadd_pkg;

    // Control state of the adder front end
    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } fsm_t;

    // Which source drives the packed result
    typedef enum logic [1:0] {
        RK_FINITE,
        RK_QNAN,
        RK_INF_A,
        RK_INF_B
    } res_kind_t;

endpackage

// File: rtl/fpadd_align.sv
`timescale 1ns/1ps
// Unpack, exponent compare, swap and alignment with guard/round/sticky.
module fpadd_align #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    output logic                  sgn_big,
    output logic                  sgn_small,
    output logic [EXP_W-1:0]      exp_big,
    output logic [FRAC_W:0]       sig_big,
    output logic [FRAC_W+3:0]     sig_al
);
    localparam int TOT   = 1 + EXP_W + FRAC_W;
    localparam int SIG_W = FRAC_W + 1;
    localparam int ALN_W = SIG_W + 3;
    localparam int SH_W  = $clog2(ALN_W + 1);

    logic [EXP_W-1:0] ea_f, eb_f, ea, eb, absd;
    logic [SIG_W-1:0] sa, sb, sig_small;
    logic [EXP_W:0]   dsub;
    logic             swap;
    logic [SH_W-1:0]  shamt;
    logic [ALN_W-1:0] ext, mask, shifted;
    logic             lost;

    // Unpack and hidden-bit rule
    always_comb begin
        ea_f = op_a[TOT-2:FRAC_W];
        eb_f = op_b[TOT-2:FRAC_W];
        ea   = (ea_f == '0) ? EXP_W'(1) : ea_f;
        eb   = (eb_f == '0) ? EXP_W'(1) : eb_f;
        sa   = {|ea_f, op_a[FRAC_W-1:0]};
        sb   = {|eb_f, op_b[FRAC_W-1:0]};
    end

    // Exponent compare by subtraction and swap multiplexer
    always_comb begin
        dsub      = {1'b0, ea} - {1'b0, eb};
        swap      = dsub[EXP_W];
        absd      = swap ? (eb - ea) : dsub[EXP_W-1:0];
        sgn_big   = swap ? op_b[TOT-1] : op_a[TOT-1];
        sgn_small = swap ? op_a[TOT-1] : op_b[TOT-1];
        exp_big   = swap ? eb : ea;
        sig_big   = swap ? sb : sa;
        sig_small = swap ? sa : sb;
    end

    // Right shift of the smaller significand; shifted-out bits fold into sticky
    always_comb begin
        if (absd >= EXP_W'(ALN_W))
            shamt = SH_W'(ALN_W);
        else
            shamt = absd[SH_W-1:0];
        ext     = {sig_small, 3'b000};
        mask    = (shamt >= SH_W'(ALN_W)) ? {ALN_W{1'b1}}
                                          : ((ALN_W'(1) << shamt) - ALN_W'(1));
        shifted = ext >> shamt;
        lost    = |(ext & mask);
        sig_al  = {shifted[ALN_W-1:1], shifted[0] | lost};
    end

endmodule

// File: rtl/fpadd_addnorm.sv
`timescale 1ns/1ps
// Effective operation, two's-complement add, sign recovery, leading-one normalize.
module fpadd_addnorm #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic              sgn_big,
    input  logic              sgn_small,
    input  logic [EXP_W-1:0]  exp_big,
    input  logic [FRAC_W:0]   sig_big,
    input  logic [FRAC_W+3:0] sig_al,
    output logic              res_sign,
    output logic              is_zero,
    output logic [FRAC_W+3:0] norm_sig,
    output logic [EXP_W:0]    norm_exp
);
    localparam int SIG_W = FRAC_W + 1;
    localparam int ALN_W = SIG_W + 3;
    localparam int MAG_W = ALN_W + 1;
    localparam int SUM_W = ALN_W + 2;
    localparam int LZ_W  = $clog2(ALN_W + 1);

    logic             eff_sub, neg;
    logic [SUM_W-1:0] big_x, small_x, addend, raw;
    logic [MAG_W-1:0] mag;
    logic [LZ_W-1:0]  lz;
    logic [EXP_W:0]   e_w, lz_w;

    // Inversion of the aligned operand plus carry-in forms the subtraction
    always_comb begin
        eff_sub  = sgn_big ^ sgn_small;
        big_x    = {2'b00, sig_big, 3'b000};
        small_x  = {2'b00, sig_al};
        addend   = eff_sub ? ~small_x : small_x;
        raw      = big_x + addend + SUM_W'(eff_sub);
        neg      = raw[SUM_W-1];
        mag      = neg ? (~raw[MAG_W-1:0] + MAG_W'(1)) : raw[MAG_W-1:0];
        is_zero  = (mag == '0);
        if (is_zero)
            res_sign = sgn_big & ~eff_sub;
        else
            res_sign = neg ? sgn_small : sgn_big;
    end

    // Leading-one detector over the in-range part of the magnitude
    always_comb begin
        lz = LZ_W'(ALN_W);
        for (int i = 0; i < ALN_W; i++) begin
            if (mag[i])
                lz = LZ_W'(ALN_W - 1 - i);
        end
    end

    // Normalization: one step right on carry, else left by the zero count
    always_comb begin
        e_w  = {1'b0, exp_big};
        lz_w = (EXP_W+1)'(lz);
        if (mag[MAG_W-1]) begin
            norm_sig = {mag[MAG_W-1:2], mag[1] | mag[0]};
            norm_exp = e_w + (EXP_W+1)'(1);
        end else if (e_w > lz_w) begin
            norm_sig = mag[ALN_W-1:0] << lz;
            norm_exp = e_w - lz_w;
        end else begin
            norm_sig = mag[ALN_W-1:0] << (e_w - (EXP_W+1)'(1));
            norm_exp = '0;
        end
    end

endmodule

// File: rtl/fpadd_round.sv
`timescale 1ns/1ps
// Round to nearest-even and pack; carry out of the fraction bumps the exponent.
module fpadd_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  res_sign,
    input  logic                  is_zero,
    input  logic [FRAC_W+3:0]     norm_sig,
    input  logic [EXP_W:0]        norm_exp,
    output logic [EXP_W+FRAC_W:0] fin_res
);
    localparam int TOT   = 1 + EXP_W + FRAC_W;
    localparam int ALN_W = FRAC_W + 4;
    localparam int BODY  = EXP_W + FRAC_W;

    logic             hid, lsb, grd, rest, up;
    logic [EXP_W-1:0] exp_f;
    logic [BODY-1:0]  base, rounded;

    always_comb begin
        hid     = norm_sig[ALN_W-1];
        exp_f   = hid ? norm_exp[EXP_W-1:0] : '0;
        base    = {exp_f, norm_sig[ALN_W-2:3]};
        lsb     = norm_sig[3];
        grd     = norm_sig[2];
        rest    = norm_sig[1] | norm_sig[0];
        up      = grd & (rest | lsb);
        rounded = base + BODY'(up);
        if (is_zero)
            fin_res = {res_sign, {(TOT-1){1'b0}}};
        else if (norm_exp >= {1'b0, {EXP_W{1'b1}}})
            fin_res = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            fin_res = {res_sign, rounded};
    end

endmodule

// File: rtl/fpadd_top.sv
`timescale 1ns/1ps
module fpadd_top
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] opnd_a,
    input  logic [EXP_W+FRAC_W:0] opnd_b,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] sum_out
);
    localparam int TOT = 1 + EXP_W + FRAC_W;
    localparam logic [TOT-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    fsm_t             state_q, state_d;
    res_kind_t        kind;
    logic [TOT-1:0]   a_q, b_q, fin;
    logic             a_max, b_max, a_nan, b_nan, a_inf, b_inf;

    logic             sgn_big, sgn_small, res_sign, is_zero;
    logic [EXP_W-1:0] exp_big;
    logic [FRAC_W:0]  sig_big;
    logic [FRAC_W+3:0] sig_al, norm_sig;
    logic [EXP_W:0]   norm_exp;

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Operand capture
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (in_valid) begin
            a_q <= opnd_a;
            b_q <= opnd_b;
        end
    end

    // Transitions
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    // Special-value classification
    always_comb begin
        a_max = &a_q[TOT-2:FRAC_W];
        b_max = &b_q[TOT-2:FRAC_W];
        a_nan = a_max & (|a_q[FRAC_W-1:0]);
        b_nan = b_max & (|b_q[FRAC_W-1:0]);
        a_inf = a_max & ~(|a_q[FRAC_W-1:0]);
        b_inf = b_max & ~(|b_q[FRAC_W-1:0]);
        if (a_nan || b_nan || (a_inf && b_inf && (a_q[TOT-1] != b_q[TOT-1])))
            kind = RK_QNAN;
        else if (a_inf)
            kind = RK_INF_A;
        else if (b_inf)
            kind = RK_INF_B;
        else
            kind = RK_FINITE;
    end

    fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .op_a      (a_q),
        .op_b      (b_q),
        .sgn_big   (sgn_big),
        .sgn_small (sgn_small),
        .exp_big   (exp_big),
        .sig_big   (sig_big),
        .sig_al    (sig_al)
    );

    fpadd_addnorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addnorm (
        .sgn_big   (sgn_big),
        .sgn_small (sgn_small),
        .exp_big   (exp_big),
        .sig_big   (sig_big),
        .sig_al    (sig_al),
        .res_sign  (res_sign),
        .is_zero   (is_zero),
        .norm_sig  (norm_sig),
        .norm_exp  (norm_exp)
    );

    fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .res_sign  (res_sign),
        .is_zero   (is_zero),
        .norm_sig  (norm_sig),
        .norm_exp  (norm_exp),
        .fin_res   (fin)
    );

    // Outputs
    always_comb begin
        out_valid = (state_q == ST_EMIT);
        unique case (kind)
            RK_FINITE: sum_out = fin;
            RK_QNAN:   sum_out = QNAN;
            RK_INF_A:  sum_out = a_q;
            RK_INF_B:  sum_out = b_q;
        endcase
    end

endmodule

// File: rtl/fpadd_chk.sv
`timescale 1ns/1ps
module fpadd_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [EXP_W+FRAC_W:0] opnd_a,
    input logic [EXP_W+FRAC_W:0] opnd_b,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] sum_out
);
    localparam int TOT = 1 + EXP_W + FRAC_W;
    localparam logic [TOT-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic a_top, b_top, a_nan, b_nan, a_inf, b_fin, a_fin;
    always_comb begin
        a_top = &opnd_a[TOT-2:FRAC_W];
        b_top = &opnd_b[TOT-2:FRAC_W];
        a_nan = a_top & (|opnd_a[FRAC_W-1:0]);
        b_nan = b_top & (|opnd_b[FRAC_W-1:0]);
        a_inf = a_top & ~(|opnd_a[FRAC_W-1:0]);
        a_fin = ~a_top;
        b_fin = ~b_top;
    end

    p_valid_follows_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_quiet_without_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_nan_gives_qnan_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (a_nan || b_nan)) |=> (sum_out == QNAN));

    p_inf_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && a_inf && b_fin) |=> (sum_out == $past(opnd_a)));

    p_cancel_to_pos_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && a_fin && (opnd_a == {~opnd_b[TOT-1], opnd_b[TOT-2:0]}))
        |=> (sum_out == '0));

endmodule

bind fpadd_top fpadd_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .out_valid (out_valid),
    .sum_out   (sum_out)
);

// File: tb/tb_fpadd_top.sv
`timescale 1ns/1ps
module tb_fpadd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        out_valid;
    logic [31:0] sum_out;

    int          nvec = 0;
    int          nbad = 0;
    int          cyc  = 0;
    logic        pend = 1'b0;
    logic [31:0] pa, pb;
    string       ptag;

    always #4 clk = ~clk;

    fpadd_top dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .out_valid (out_valid),
        .sum_out   (sum_out)
    );

    // Exact model: align to the smaller exponent in a wide integer, add, round
    function automatic logic [31:0] ref_add(input logic [31:0] a, input logic [31:0] b);
        logic         an, bn, ai, bi, sg;
        logic [319:0] va, vb, mag, q, rem, half;
        int           xa, xb, emin, p, sh, e;
        an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        ai = (a[30:23] == 8'hFF) && (a[22:0] == 0);
        bi = (b[30:23] == 8'hFF) && (b[22:0] == 0);
        if (an || bn || (ai && bi && (a[31] != b[31]))) return 32'h7FC00000;
        if (ai) return a;
        if (bi) return b;
        xa   = (a[30:23] == 0) ? 1 : int'(a[30:23]);
        xb   = (b[30:23] == 0) ? 1 : int'(b[30:23]);
        emin = (xa < xb) ? xa : xb;
        va   = {296'd0, (a[30:23] != 0), a[22:0]} << (xa - emin);
        vb   = {296'd0, (b[30:23] != 0), b[22:0]} << (xb - emin);
        if (a[31] == b[31]) begin
            mag = va + vb; sg = a[31];
        end else if (va >= vb) begin
            mag = va - vb; sg = a[31];
        end else begin
            mag = vb - va; sg = b[31];
        end
        if (mag == 0) return {a[31] & b[31], 31'd0};
        p = -1;
        for (int i = 0; i < 320; i++) if (mag[i]) p = i;
        e = p + emin - 23;
        if (e < 1) begin
            q = mag << (emin - 1);
            return {sg, 8'd0, q[22:0]};
        end
        sh = p - 23;
        if (sh <= 0) begin
            q = mag << (-sh);
        end else begin
            q    = mag >> sh;
            rem  = mag & ((320'd1 << sh) - 320'd1);
            half = 320'd1 << (sh - 1);
            if (rem > half || (rem == half && q[0])) q = q + 320'd1;
        end
        if (q[24]) begin
            q = q >> 1;
            e = e + 1;
        end
        if (e >= 255) return {sg, 8'hFF, 23'd0};
        return {sg, e[7:0], q[22:0]};
    endfunction

    function automatic string tag_of(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        r = ref_add(a, b);
        if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0)) return "R9";
        if (a[30:23] == 8'hFF && b[30:23] == 8'hFF && a[31] != b[31]) return "R9";
        if (a[30:23] == 8'hFF || b[30:23] == 8'hFF) return "R10";
        if (r[30:0] == 31'h7F800000) return "R8";
        if (r[30:0] == 0) return "R4";
        if (a[30:23] == 0 || b[30:23] == 0 || r[30:23] == 0) return "R5";
        if (a[31] != b[31]) return "R3";
        return "R2";
    endfunction

    task automatic check_pending();
        logic [31:0] expv;
        if (pend) begin
            nvec++;
            expv = ref_add(pa, pb);
            if (out_valid !== 1'b1) begin
                nbad++;
                $display("FAIL R1 out_valid for %h+%h: actual=%b expected=1", pa, pb, out_valid);
            end else if (sum_out !== expv) begin
                nbad++;
                $display("FAIL %s %h+%h: actual=%h expected=%h", ptag, pa, pb, sum_out, expv);
            end
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        check_pending();
        opnd_a   = a;
        opnd_b   = b;
        in_valid = 1'b1;
        pa       = a;
        pb       = b;
        ptag     = (tag == "") ? tag_of(a, b) : tag;
        pend     = 1'b1;
    endtask

    // Withdraw the strobe and confirm out_valid drops a cycle later (R1)
    task automatic go_idle();
        @(negedge clk);
        check_pending();
        pend     = 1'b0;
        in_valid = 1'b0;
        opnd_a   = 32'h3F800000;
        opnd_b   = 32'h40000000;
        @(negedge clk);
        nvec++;
        if (out_valid !== 1'b0) begin
            nbad++;
            $display("FAIL R1 idle: actual=%b expected=0", out_valid);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            nbad++;
            $display("FAIL R1 watchdog: actual=%0d cycles expected=<190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        int exps[19] = '{0, 1, 2, 3, 25, 26, 27, 100, 101, 102, 126, 127, 128, 152, 153, 154, 253, 254, 255};
        int fracs[6] = '{0, 1, 'h400000, 'h7FFFFF, 'h2AAAAA, 3};
        logic [31:0] ra, rb;

        // Reset state (R1)
        repeat (3) @(negedge clk);
        nvec++;
        if (out_valid !== 1'b0) begin
            nbad++;
            $display("FAIL R1 reset: actual=%b expected=0", out_valid);
        end
        rst = 1'b0;
        @(negedge clk);
        nvec++;
        if (out_valid !== 1'b0) begin
            nbad++;
            $display("FAIL R1 after reset: actual=%b expected=0", out_valid);
        end

        // Directed corners
        put(32'h3F800000, 32'h40000000, "R2");
        put(32'h3F800000, 32'hC0000000, "R3");   // smaller first, sign of larger
        put(32'hC0400000, 32'h3F800000, "R3");
        put(32'h3F800000, 32'hBF800000, "R4");   // +0
        put(32'h80000000, 32'h80000000, "R4");   // -0
        put(32'h00000000, 32'h80000000, "R4");
        put(32'h00000001, 32'h00000001, "R5");
        put(32'h00800000, 32'h80000001, "R5");   // normal minus tiny -> subnormal
        put(32'h007FFFFF, 32'h00000001, "R5");   // subnormal sum becomes normal
        put(32'h3F800000, 32'h33800000, "R6");   // tie, even kept
        put(32'h3F800001, 32'h33800000, "R6");   // tie, odd rounds up
        put(32'h3F800000, 32'h33800001, "R6");   // above half
        put(32'h3F800000, 32'hB3000000, "R6");   // tie below one
        put(32'h3F800000, 32'h32800000, "R7");   // diff 26
        put(32'h3F800000, 32'hB2800000, "R7");
        put(32'h3F800000, 32'h0DA00000, "R7");
        put(32'hBF800000, 32'h0DA00000, "R7");
        put(32'h7F7FFFFF, 32'h7F7FFFFF, "R8");
        put(32'hFF7FFFFF, 32'hFF000000, "R8");
        put(32'h7F7FFFFF, 32'h73000000, "R8");   // overflow via rounding carry
        put(32'h7F800000, 32'hFF800000, "R9");
        put(32'h7FC00001, 32'h3F800000, "R9");
        put(32'h3F800000, 32'hFF812345, "R9");
        put(32'hFF800000, 32'h3F800000, "R10");
        put(32'h12345678, 32'h7F800000, "R10");
        put(32'h7F800000, 32'h7F800000, "R10");
        go_idle();

        // Sweep over a grid of signs, exponents and fraction patterns
        for (int i = 0; i < 228; i++) begin
            for (int j = 0; j < 228; j++) begin
                ra = {i[0], 8'(exps[(i / 2) % 19]), 23'(fracs[i / 38])};
                rb = {j[0], 8'(exps[(j / 2) % 19]), 23'(fracs[j / 38])};
                put(ra, rb, "");
            end
        end
        go_idle();

        // Scattered operands, half of them with nearby exponents
        for (int k = 0; k < 6000; k++) begin
            ra = $urandom;
            rb = $urandom;
            if (k[0]) rb[30:23] = ra[30:23] ^ 8'($urandom % 4);
            put(ra, rb, "");
        end
        go_idle();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule